// File: doc/BRIEF.md
# Dual-width system register bank

This block keeps three 64-bit system registers for a processor's memory-management logic: one register that receives address-translation results, and two translation-table base registers. Each register is held as a low and a high 32-bit half. Software reaches them through coprocessor-style requests that carry a coprocessor number, a CRm field and an opc1 field. A request uses either a narrow 32-bit path, which touches only the low half, or a wide paired-transfer path, which moves the whole 64-bit value.

The two paths have different side effects. Narrow writes to the translation-result register are masked according to two feature inputs. A narrow translation result from the translation unit clears the high half of that register. A wide write to base register 0 raises a one-cycle TLB-flush pulse, because it may change the address-space identifier. A request that is unprivileged, undecodable, or wide while wide addressing is disabled is refused with an error flag and changes nothing. Read data and all responses are registered one cycle behind the request.

Top module: `sysreg_wide_bank`

## Requirements
- R1: After reset both halves of all three registers read as zero, and rvalid, undef_err and tlb_flush are low.
- R2: A wide read returns {high half, low half} on rdata. A wide write loads the high half from wdata[63:32] and the low half from wdata[31:0].
- R3: A narrow write to the translation-result register stores wdata[31:0] ANDed with a mask. The mask is all ones when feat_wide_addr is 1. It is 0xFFFFF6FF (bits 8 and 11 cleared) when only feat_newer_mask is 1. It is 0xFFFFF1FF (bits 9, 10 and 11 cleared) when both features are 0.
- R4: A narrow read returns {32'b0, low half}. A narrow write changes only the low half and applies no mask to the two base registers.
- R5: A pulse on xlat_done stores xlat_result into the low half of the translation-result register and clears its high half. If a software write to that register arrives in the same cycle, the translation result takes priority.
- R6: tlb_flush is high for exactly one cycle, the cycle after an accepted wide write to base register 0. Wide writes to the other registers and all narrow writes leave it low.
- R7: Decoding uses coprocessor 15 in every case. CRm 7 with opc1 0 selects the translation-result register. CRm 2 with opc1 0 selects base 0. CRm 2 with opc1 1 selects base 1. Every other combination is refused.
- R8: A request with req_priv low is refused, and no register changes.
- R9: A wide request while feat_wide_addr is 0 is refused, and no register changes.
- R10: A refused request raises undef_err for one cycle, in the cycle after the request, with rvalid low. An accepted read raises rvalid with its data in that same cycle after the request. A write takes effect at the clock edge of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_newer_mask | input | 1 | Selects the narrower result-register write mask |
| feat_wide_addr | input | 1 | Large-address feature; enables the wide path and unmasked narrow writes |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit paired transfer, 0 = 32-bit |
| req_priv | input | 1 | Requester is privileged |
| req_cp | input | 4 | Coprocessor number |
| req_crm | input | 4 | CRm field |
| req_opc1 | input | 3 | opc1 field |
| wdata | input | 64 | Write data; a narrow write uses bits 31:0 |
| xlat_done | input | 1 | Narrow translation result is ready |
| xlat_result | input | 32 | Translation result value |
| rdata | output | 64 | Registered read data |
| rvalid | output | 1 | Read data valid |
| undef_err | output | 1 | Request refused |
| tlb_flush | output | 1 | One-cycle TLB-flush pulse |

## Verification
The bench builds the block with its default 32-bit halves and three registers. Because the decode fields are only 4, 4 and 3 bits wide, every coprocessor/CRm/opc1 combination (2048 in all) can be swept, with the accept or refuse outcome computed in the bench. All four settings of the two feature inputs are applied to an all-ones narrow write, so every mask bit is observed. Directed sequences then cover the flush pulse, high-half clearing, the priority of a same-cycle translation result, and refusal without any state change.

// File: rtl/sysreg_wide_pkg.sv
package sysreg_wide_pkg;
  localparam int HALF_W = 32;
  localparam int FULL_W = 2 * HALF_W;
  localparam int CP_W   = 4;
  localparam int CRM_W  = 4;
  localparam int OPC_W  = 3;
  localparam int NREG   = 3;
  localparam int IDX_W  = $clog2(NREG);

  localparam logic [CP_W-1:0]  CP_SYS    = 4'd15;
  localparam logic [CRM_W-1:0] CRM_XRES  = 4'd7;
  localparam logic [CRM_W-1:0] CRM_TBASE = 4'd2;

  typedef enum logic [IDX_W-1:0] {
    REG_XRES = 2'd0,
    REG_TB0  = 2'd1,
    REG_TB1  = 2'd2
  } reg_id_e;

  // Mask for a narrow software write to the translation-result register.
  function automatic logic [HALF_W-1:0] xres_mask32(input logic f_newer, input logic f_wide);
    logic [HALF_W-1:0] m;
    m = '1;
    if (!f_wide) begin
      m[11] = 1'b0;
      if (f_newer) begin
        m[8] = 1'b0;
      end else begin
        m[9]  = 1'b0;
        m[10] = 1'b0;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/sysreg_wide_decode.sv
module sysreg_wide_decode
  import sysreg_wide_pkg::*;
(
  input  logic             valid,
  input  logic             wide,
  input  logic             priv,
  input  logic             feat_wide,
  input  logic [CP_W-1:0]  cp,
  input  logic [CRM_W-1:0] crm,
  input  logic [OPC_W-1:0] opc1,
  output reg_id_e          idx,
  output logic             accept,
  output logic             reject
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    idx = REG_XRES;
    if (cp == CP_SYS) begin
      if (crm == CRM_XRES && opc1 == '0) begin
        hit = 1'b1;
        idx = REG_XRES;
      end else if (crm == CRM_TBASE && opc1 == '0) begin
        hit = 1'b1;
        idx = REG_TB0;
      end else if (crm == CRM_TBASE && opc1 == OPC_W'(1)) begin
        hit = 1'b1;
        idx = REG_TB1;
      end
    end
  end

  assign accept = valid && hit && priv && (!wide || feat_wide);
  assign reject = valid && !accept;
endmodule

// File: rtl/sysreg_wide_cell.sv
module sysreg_wide_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lo_we,
  input  logic [W-1:0] lo_d,
  input  logic         hi_we,
  input  logic [W-1:0] hi_d,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= lo_d;
      if (hi_we) hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/sysreg_wide_bank.sv
module sysreg_wide_bank
  import sysreg_wide_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_newer_mask,
  input  logic              feat_wide_addr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic              req_priv,
  input  logic [CP_W-1:0]   req_cp,
  input  logic [CRM_W-1:0]  req_crm,
  input  logic [OPC_W-1:0]  req_opc1,
  input  logic [FULL_W-1:0] wdata,
  input  logic              xlat_done,
  input  logic [HALF_W-1:0] xlat_result,
  output logic [FULL_W-1:0] rdata,
  output logic              rvalid,
  output logic              undef_err,
  output logic              tlb_flush
);
  reg_id_e idx;
  logic    acc_evt, rej_evt, wr_evt, rd_evt, flush_evt;

  logic [HALF_W-1:0] lo_q [NREG];
  logic [HALF_W-1:0] hi_q [NREG];
  logic [HALF_W-1:0] lo_d [NREG];
  logic [HALF_W-1:0] hi_d [NREG];
  logic              lo_we [NREG];
  logic              hi_we [NREG];
  logic [FULL_W-1:0] rd_mux;

  sysreg_wide_decode u_dec (
    .valid     (req_valid),
    .wide      (req_wide),
    .priv      (req_priv),
    .feat_wide (feat_wide_addr),
    .cp        (req_cp),
    .crm       (req_crm),
    .opc1      (req_opc1),
    .idx       (idx),
    .accept    (acc_evt),
    .reject    (rej_evt)
  );

  assign wr_evt    = acc_evt && req_write;
  assign rd_evt    = acc_evt && !req_write;
  assign flush_evt = wr_evt && req_wide && (idx == REG_TB0);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IS_XRES = (g == int'(REG_XRES));
    logic sel;
    logic xl;
    assign sel = wr_evt && (int'(idx) == g);
    assign xl  = IS_XRES && xlat_done;

    always_comb begin
      lo_we[g] = sel || xl;
      hi_we[g] = (sel && req_wide) || xl;
      hi_d[g]  = xl ? '0 : wdata[FULL_W-1:HALF_W];
      if (xl)
        lo_d[g] = xlat_result;
      else if (!req_wide && IS_XRES)
        lo_d[g] = wdata[HALF_W-1:0] & xres_mask32(feat_newer_mask, feat_wide_addr);
      else
        lo_d[g] = wdata[HALF_W-1:0];
    end

    sysreg_wide_cell #(.W(HALF_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_we (lo_we[g]),
      .lo_d  (lo_d[g]),
      .hi_we (hi_we[g]),
      .hi_d  (hi_d[g]),
      .lo_q  (lo_q[g]),
      .hi_q  (hi_q[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(idx) == i)
        rd_mux = {(req_wide ? hi_q[i] : {HALF_W{1'b0}}), lo_q[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rvalid    <= 1'b0;
      undef_err <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      rdata     <= rd_evt ? rd_mux : '0;
      rvalid    <= rd_evt;
      undef_err <= rej_evt;
      tlb_flush <= flush_evt;
    end
  end

  // R5: a translation result always leaves the high half cleared
  a_r5_xlat_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_done |=> (hi_q[0] == '0));

  // R6: the flush pulse traces back to a wide base-0 write
  a_r6_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(flush_evt));

  // R8: a refused request disturbs no register
  a_r8_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_evt && !xlat_done) |=> ($stable(lo_q[0]) && $stable(hi_q[0]) &&
      $stable(lo_q[1]) && $stable(hi_q[1]) && $stable(lo_q[2]) && $stable(hi_q[2])));

  // R9: wide requests are refused while the wide feature is off
  a_r9_wide_needs_feature: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wide && !feat_wide_addr) |-> rej_evt);

  // R10: responses are mutually exclusive and follow their request
  a_r10_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rvalid, undef_err}));
  a_r10_rvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_evt));
endmodule

// File: tb/sysreg_wide_bank_test.sv
module sysreg_wide_bank_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_newer_mask = 1'b1;
  logic        feat_wide_addr = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_priv = 1'b1;
  logic [3:0]  req_cp = '0, req_crm = '0;
  logic [2:0]  req_opc1 = '0;
  logic [63:0] wdata = '0;
  logic        xlat_done = 1'b0;
  logic [31:0] xlat_result = '0;
  logic [63:0] rdata;
  logic        rvalid, undef_err, tlb_flush;

  int vecs = 0;
  int fails = 0;

  logic [63:0] g_rd;
  logic        g_rv, g_ud, g_fl;

  always #(CLK_P/2) clk = ~clk;

  sysreg_wide_bank uut (
    .clk(clk), .rst_n(rst_n), .feat_newer_mask(feat_newer_mask), .feat_wide_addr(feat_wide_addr),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide), .req_priv(req_priv),
    .req_cp(req_cp), .req_crm(req_crm), .req_opc1(req_opc1), .wdata(wdata),
    .xlat_done(xlat_done), .xlat_result(xlat_result),
    .rdata(rdata), .rvalid(rvalid), .undef_err(undef_err), .tlb_flush(tlb_flush)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One request; outputs captured just after the edge that registers them.
  task automatic acc(input logic wr, input logic wd, input logic [3:0] cp,
                     input logic [3:0] crm, input logic [2:0] op, input logic pv,
                     input logic [63:0] d);
    req_valid = 1'b1; req_write = wr; req_wide = wd; req_cp = cp;
    req_crm = crm; req_opc1 = op; req_priv = pv; wdata = d;
    @(posedge clk); #1;
    g_rd = rdata; g_rv = rvalid; g_ud = undef_err; g_fl = tlb_flush;
    req_valid = 1'b0; xlat_done = 1'b0;
    @(posedge clk); #1;
  endtask

  // Register selectors by index: 0 result, 1 base0, 2 base1
  function automatic logic [3:0] crm_of(input int r);
    return (r == 0) ? 4'd7 : 4'd2;
  endfunction
  function automatic logic [2:0] op_of(input int r);
    return (r == 2) ? 3'd1 : 3'd0;
  endfunction

  task automatic rd64(input int r);
    acc(1'b0, 1'b1, 4'd15, crm_of(r), op_of(r), 1'b1, 64'd0);
  endtask
  task automatic wr64(input int r, input logic [63:0] d);
    acc(1'b1, 1'b1, 4'd15, crm_of(r), op_of(r), 1'b1, d);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [63:0] pat [3];
    logic [31:0] m;
    pat[0] = 64'hA5A5_0001_1234_5678;
    pat[1] = 64'h0F0F_F0F0_DEAD_BEEF;
    pat[2] = 64'h8000_0001_7FFF_FFFE;
    #(CLK_P * 2 + 1);
    // R1 reset state
    chk("R1 rvalid", {63'd0, rvalid}, 64'd0);
    chk("R1 undef", {63'd0, undef_err}, 64'd0);
    chk("R1 flush", {63'd0, tlb_flush}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int r = 0; r < 3; r++) begin
      rd64(r);
      chk("R1 reset value", g_rd, 64'd0);
    end

    // R7 R10: full decode sweep of reads
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 16; k++)
        for (int o = 0; o < 8; o++) begin
          logic hit;
          hit = (c == 15) && ((k == 7 && o == 0) || (k == 2 && o < 2));
          acc(1'b0, logic'((c ^ k) & 1), 4'(c), 4'(k), 3'(o), 1'b1, 64'd0);
          chk("R7 decode undef", {63'd0, g_ud}, {63'd0, !hit});
          chk("R10 decode rvalid", {63'd0, g_rv}, {63'd0, hit});
        end

    // R2 R6: wide writes, read back, flush only for base 0
    for (int r = 0; r < 3; r++) begin
      wr64(r, pat[r]);
      chk("R10 write no rvalid", {63'd0, g_rv}, 64'd0);
      chk("R6 flush", {63'd0, g_fl}, {63'd0, (r == 1)});
      chk("R6 flush one cycle", {63'd0, tlb_flush}, 64'd0);
    end
    for (int r = 0; r < 3; r++) begin
      rd64(r);
      chk("R2 wide read", g_rd, pat[r]);
      acc(1'b0, 1'b0, 4'd15, crm_of(r), op_of(r), 1'b1, 64'd0);
      chk("R4 narrow read", g_rd, {32'd0, pat[r][31:0]});
    end

    // R4: narrow writes to base regs, no mask, high kept, no flush
    for (int r = 1; r < 3; r++) begin
      acc(1'b1, 1'b0, 4'd15, crm_of(r), op_of(r), 1'b1, 64'hCAFE_0000_FFFF_FFFF);
      chk("R6 narrow no flush", {63'd0, g_fl}, 64'd0);
      rd64(r);
      chk("R4 narrow write", g_rd, {pat[r][63:32], 32'hFFFF_FFFF});
    end

    // R3: mask sweep over feature settings
    for (int f = 0; f < 4; f++) begin
      feat_newer_mask = f[0];
      feat_wide_addr  = f[1];
      m = 32'hFFFF_FFFF;
      if (!f[1]) begin
        if (f[0]) m = m & ~((32'd1 << 8) | (32'd1 << 11));
        else      m = m & ~(32'd7 << 9);
      end
      acc(1'b1, 1'b0, 4'd15, 4'd7, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      acc(1'b0, 1'b0, 4'd15, 4'd7, 3'd0, 1'b1, 64'd0);
      chk("R3 mask", g_rd, {32'd0, m});
    end
    feat_wide_addr = 1'b1;
    feat_newer_mask = 1'b1;
    rd64(0);
    chk("R3 high half untouched", g_rd[63:32], {32'd0, pat[0][63:32]});

    // R8: unprivileged write refused, state unchanged
    acc(1'b1, 1'b1, 4'd15, 4'd2, 3'd0, 1'b0, 64'h1111_2222_3333_4444);
    chk("R8 undef", {63'd0, g_ud}, 64'd1);
    chk("R8 no flush", {63'd0, g_fl}, 64'd0);
    rd64(1);
    chk("R8 state kept", g_rd, {pat[1][63:32], 32'hFFFF_FFFF});

    // R9: wide access with feature off
    feat_wide_addr = 1'b0;
    acc(1'b1, 1'b1, 4'd15, 4'd2, 3'd1, 1'b1, 64'h5555_5555_5555_5555);
    chk("R9 wide write undef", {63'd0, g_ud}, 64'd1);
    acc(1'b0, 1'b1, 4'd15, 4'd2, 3'd1, 1'b1, 64'd0);
    chk("R9 wide read undef", {63'd0, g_ud}, 64'd1);
    chk("R9 wide read no rvalid", {63'd0, g_rv}, 64'd0);
    acc(1'b0, 1'b0, 4'd15, 4'd2, 3'd1, 1'b1, 64'd0);
    chk("R9 narrow still ok", g_rd, 64'h0000_0000_FFFF_FFFF);
    feat_wide_addr = 1'b1;
    rd64(2);
    chk("R9 state kept", g_rd, {pat[2][63:32], 32'hFFFF_FFFF});

    // R5: translation result clears the high half
    wr64(0, 64'h9999_8888_7777_6666);
    xlat_done = 1'b1; xlat_result = 32'h0000_ABCD;
    @(posedge clk); #1;
    xlat_done = 1'b0;
    rd64(0);
    chk("R5 xlat store", g_rd, 64'h0000_0000_0000_ABCD);

    // R5: translation result wins over a same-cycle wide write
    xlat_done = 1'b1; xlat_result = 32'h1357_9BDF;
    wr64(0, 64'hFFFF_FFFF_0000_0000);
    rd64(0);
    chk("R5 xlat priority", g_rd, 64'h0000_0000_1357_9BDF);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule